// File: doc/BRIEF.md
# Lockable Memory-Controller Configuration Register File

This block holds the configuration space of a DRAM controller: 320 words of 32 bits, 0x500 bytes in all, reached through a word-indexed bus port. A write takes effect on the next rising clock edge. A read returns data combinationally from the index presented. The block holds no DRAM timing or training logic. At reset it loads PHY status and eye-window values that report a calibrated interface in which every lane passes, so firmware that polls those words can move on at once.

Word 0 is a protection register. Writing a key to it opens, soft-locks or hard-locks the rest of the space. A soft lock blocks ordinary writes but still accepts a new key. A hard lock blocks every ordinary write, the protection word included, until system reset. A fixed set of eight words (scratch, test and interrupt words) stays writable in every lock state.

Word 1 is a configuration word. It merges writable bits with read-only fields: a hardware version, a VGA aperture code and a RAM-size code. The block finds the RAM-size code by searching the table of allowed sizes for the value on the `ram_mib` input.

Top module: `dmc_cfg_regfile`

## Requirements
- R1: After reset, every word reads 0 except these: word 0x100 (byte 0x400) reads 0x00000002, word 0x11A (byte 0x468) reads 0x000000FF, word 0x11F (byte 0x47C) reads 0x000000FF, and word 0x114 (byte 0x450) reads 0x0FFFFFFF. Word 1 also shows its fixed fields. The protection word reads 0, which means open.
- R2: The protection word (index 0) reads back the lock state in bits [1:0], with 0 = open, 1 = soft, 2 = hard, and 0 in all upper bits. When the block is not hard-locked, a write of 0xFC600309 opens it, a write of 0xDEADDEAD hard-locks it, and any other value soft-locks it.
- R3: While soft-locked, a write to any word that is neither on the always-writable list nor the protection word leaves that word unchanged. Writes to the protection word are still processed.
- R4: While hard-locked, every write outside the always-writable list is ignored, including writes to the protection word that carry the unlock key. Only a system reset leaves the hard lock.
- R5: Writes to word indices 0x14, 0x1B, 0x1D, 0x1E, 0x1F, 0x22, 0x23 and 0x2D (byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C, 0xB4) store the full data in every lock state.
- R6: Bits [1:0] of word 1 hold the index of `ram_mib` in the allowed list: 256 gives 0, 512 gives 1, 1024 gives 2 and 2048 gives 3. The field follows the input combinationally.
- R7: When `ram_mib` is not in the allowed list, `size_err` is 1 and bits [1:0] of word 1 read 0. Otherwise `size_err` is 0.
- R8: Word 1 always reads 3 in bits [31:28] and 2'b11 (the 64 MiB aperture code) in bits [3:2]. Writes to bits [31:28] and [3:0] have no effect, and its other bits store what is written.
- R9: A read at any index of 320 or above (byte offset 0x500 and up) returns 0, and a write there changes no word.
- R10: While open, a write to any word other than 0 stores the data; for word 1 only the writable bits are stored. A read in a later cycle returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| ram_mib | input | 12 | Configured RAM size in MiB |
| bus_widx | input | 10 | Word index (byte offset divided by 4) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_widx` |
| size_err | output | 1 | `ram_mib` not in the allowed list |

## Verification
The hardest situation to reach is a hard lock followed by attempts to escape it. After the bench has set the hard lock, it writes the unlock key and then every other value it used, and then writes a fresh pattern to every index. Each word in the space must then read either its pre-lock value or, for the eight always-writable words, the new data. A system reset must then return every word to its default. The bench also sweeps `ram_mib` across the allowed sizes and a set of illegal ones while the configuration word holds all-ones writable bits, so that the size code cannot be confused with stored data.

// File: rtl/dmc_cfg_pkg.sv
package dmc_cfg_pkg;

    localparam int DATA_W    = 32;
    localparam int IDX_W     = 10;
    localparam int NUM_WORDS = 320;
    localparam int SIZE_W    = 12;
    localparam int NUM_SIZES = 4;
    localparam int CODE_W    = 2;
    localparam int BASE_MIB  = 256;

    localparam int PROT_IDX  = 0;
    localparam int CONF_IDX  = 1;

    localparam logic [31:0] UNLOCK_KEY   = 32'hFC60_0309;
    localparam logic [31:0] HARD_KEY     = 32'hDEAD_DEAD;
    localparam logic [31:0] CONF_RO_MASK = 32'hF000_000F;
    localparam logic [31:0] CONF_FIXED   = 32'h3000_000C;

    typedef enum logic [1:0] {
        LK_OPEN = 2'd0,
        LK_SOFT = 2'd1,
        LK_HARD = 2'd2
    } lock_e;

    typedef struct packed {
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Words that accept writes whatever the lock state.
    function automatic logic is_free_word(input int unsigned idx);
        case (idx)
            32'h14, 32'h1B, 32'h1D, 32'h1E,
            32'h1F, 32'h22, 32'h23, 32'h2D: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    // PHY status and eye-window defaults; all else clears.
    function automatic logic [31:0] reset_value(input int unsigned idx);
        case (idx)
            32'h100: return 32'h0000_0002;
            32'h114: return 32'h0FFF_FFFF;
            32'h11A: return 32'h0000_00FF;
            32'h11F: return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction

    // Allowed sizes double from the base entry.
    function automatic int unsigned allowed_mib(input int unsigned i);
        return BASE_MIB << i;
    endfunction

endpackage

// File: rtl/dmc_size_encoder.sv
module dmc_size_encoder
    import dmc_cfg_pkg::*;
#(
    parameter int S_W = SIZE_W,
    parameter int N_S = NUM_SIZES,
    parameter int C_W = CODE_W
) (
    input  logic [S_W-1:0] ram_mib,
    output logic [C_W-1:0] code,
    output logic           err
);
    logic [N_S-1:0] hit;

    for (genvar g = 0; g < N_S; g++) begin : g_cmp
        assign hit[g] = (ram_mib == S_W'(allowed_mib(g)));
    end

    always_comb begin
        code = '0;
        for (int i = N_S - 1; i >= 0; i--) begin
            if (hit[i]) code = C_W'(i);
        end
    end

    assign err = (hit == '0);
endmodule

// File: rtl/dmc_lock_ctrl.sv
module dmc_lock_ctrl
    import dmc_cfg_pkg::*;
#(
    parameter int I_W = IDX_W,
    parameter int N_W = NUM_WORDS
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    output lock_e   lock_state,
    output logic    grant
);
    logic in_range, free, to_prot;

    assign in_range = (req.idx < I_W'(N_W));
    assign free     = is_free_word(32'(req.idx));
    assign to_prot  = (req.idx == I_W'(PROT_IDX));

    assign grant = req.wr && in_range &&
                   (free || (lock_state == LK_OPEN && !to_prot));

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_state <= LK_OPEN;
        end else if (req.wr && to_prot && lock_state != LK_HARD) begin
            if (req.data == UNLOCK_KEY)    lock_state <= LK_OPEN;
            else if (req.data == HARD_KEY) lock_state <= LK_HARD;
            else                           lock_state <= LK_SOFT;
        end
    end
endmodule

// File: rtl/dmc_reg_array.sv
module dmc_reg_array
    import dmc_cfg_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int I_W = IDX_W,
    parameter int N_W = NUM_WORDS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           grant,
    input  wr_req_t        req,
    output logic [D_W-1:0] words [N_W]
);
    localparam logic [D_W-1:0] KEEP_MASK = ~D_W'(CONF_RO_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_W; i++) begin
                words[i] <= D_W'(reset_value(i));
            end
        end else if (grant) begin
            if (req.idx == I_W'(CONF_IDX)) words[req.idx] <= D_W'(req.data) & KEEP_MASK;
            else                           words[req.idx] <= D_W'(req.data);
        end
    end
endmodule

// File: rtl/dmc_cfg_regfile.sv
module dmc_cfg_regfile
    import dmc_cfg_pkg::*;
#(
    parameter int N_W = NUM_WORDS,
    parameter int I_W = IDX_W,
    parameter int S_W = SIZE_W,
    parameter int N_S = NUM_SIZES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [S_W-1:0]    ram_mib,
    input  logic [I_W-1:0]    bus_widx,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              size_err
);
    localparam int C_W = (N_S > 1) ? $clog2(N_S) : 1;

    wr_req_t           req;
    lock_e             lock_state;
    logic              wr_grant;
    logic [C_W-1:0]    size_code;
    logic [DATA_W-1:0] words [N_W];

    assign req.wr   = bus_wr;
    assign req.idx  = bus_widx;
    assign req.data = bus_wdata;

    dmc_size_encoder #(.S_W(S_W), .N_S(N_S), .C_W(C_W)) u_size (
        .ram_mib (ram_mib),
        .code    (size_code),
        .err     (size_err)
    );

    dmc_lock_ctrl #(.I_W(I_W), .N_W(N_W)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .lock_state (lock_state),
        .grant      (wr_grant)
    );

    dmc_reg_array #(.D_W(DATA_W), .I_W(I_W), .N_W(N_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .grant (wr_grant),
        .req   (req),
        .words (words)
    );

    always_comb begin
        if (bus_widx >= I_W'(N_W)) begin
            bus_rdata = '0;
        end else if (bus_widx == I_W'(PROT_IDX)) begin
            bus_rdata = {30'b0, lock_state};
        end else if (bus_widx == I_W'(CONF_IDX)) begin
            bus_rdata = (words[CONF_IDX] & ~CONF_RO_MASK) | CONF_FIXED
                      | DATA_W'(size_code);
        end else begin
            bus_rdata = words[bus_widx];
        end
    end
endmodule

// File: rtl/dmc_cfg_checker.sv
module dmc_cfg_checker
    import dmc_cfg_pkg::*;
#(
    parameter int N_W = NUM_WORDS,
    parameter int I_W = IDX_W
) (
    input logic              clk,
    input logic              rst,
    input logic [I_W-1:0]    bus_widx,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        lock_state,
    input logic              wr_grant,
    input logic [1:0]        size_code,
    input logic              size_err
);
    // R4
    hard_lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_state == 2'd2 |=> lock_state == 2'd2);

    // R4
    hard_lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_state == 2'd2 && bus_wr && !is_free_word(32'(bus_widx))) |-> !wr_grant);

    // R3
    soft_lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_state == 2'd1 && bus_wr && !is_free_word(32'(bus_widx))) |-> !wr_grant);

    // R2
    soft_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_state == 2'd1 && bus_wr && bus_widx == '0 && bus_wdata == UNLOCK_KEY)
        |=> lock_state == 2'd0);

    // R5
    free_word_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_free_word(32'(bus_widx))) |-> wr_grant);

    // R7
    bad_size_code_chk: assert property (@(posedge clk) disable iff (rst)
        size_err |-> size_code == 2'd0);

    // R8
    conf_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        bus_widx == I_W'(CONF_IDX) |-> (bus_rdata[31:28] == 4'd3 && bus_rdata[3:2] == 2'b11));

    // R9
    out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
        bus_widx >= I_W'(N_W) |-> (bus_rdata == '0 && !wr_grant));
endmodule

bind dmc_cfg_regfile dmc_cfg_checker #(.N_W(N_W), .I_W(I_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_widx   (bus_widx),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .lock_state (lock_state),
    .wr_grant   (wr_grant),
    .size_code  (2'(size_code)),
    .size_err   (size_err)
);

// File: tb/tb_dmc_cfg_regfile.sv
module tb_dmc_cfg_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ram_mib = 12'd256;
    logic [9:0]  bus_widx = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        size_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] mdl [320];
    int          mdl_lock;

    always #10 clk = ~clk;

    dmc_cfg_regfile dut (
        .clk       (clk),
        .rst       (rst),
        .ram_mib   (ram_mib),
        .bus_widx  (bus_widx),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .size_err  (size_err)
    );

    function automatic bit free_idx(input int i);
        return i == 'h14 || i == 'h1B || i == 'h1D || i == 'h1E ||
               i == 'h1F || i == 'h22 || i == 'h23 || i == 'h2D;
    endfunction

    function automatic int size_code_of(input int mib);
        for (int k = 0; k < 4; k++) if (mib == (256 * (1 << k))) return k;
        return -1;
    endfunction

    function automatic logic [31:0] mdl_read(input int i);
        int c;
        if (i >= 320) return 32'h0;
        if (i == 0) return 32'(mdl_lock);
        if (i == 1) begin
            c = size_code_of(int'(ram_mib));
            if (c < 0) c = 0;
            return (mdl[1] & 32'h0FFF_FFF0) | 32'h3000_000C | 32'(c);
        end
        return mdl[i];
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 320; i++) mdl[i] = 32'h0;
        mdl['h100] = 32'h2;
        mdl['h114] = 32'h0FFF_FFFF;
        mdl['h11A] = 32'hFF;
        mdl['h11F] = 32'hFF;
        mdl_lock = 0;
    endtask

    task automatic mdl_write(input int i, input logic [31:0] d);
        if (i >= 320) return;
        if (free_idx(i)) begin
            mdl[i] = d;
        end else if (i == 0) begin
            if (mdl_lock != 2) begin
                if (d == 32'hFC60_0309)      mdl_lock = 0;
                else if (d == 32'hDEAD_DEAD) mdl_lock = 2;
                else                         mdl_lock = 1;
            end
        end else if (mdl_lock == 0) begin
            mdl[i] = (i == 1) ? (d & 32'h0FFF_FFF0) : d;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mdl_reset();
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        @(negedge clk);
        bus_widx  = 10'(i);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        mdl_write(i, d);
    endtask

    task automatic rd(input int i, input string tag);
        @(negedge clk);
        bus_widx = 10'(i);
        #2;
        chk($sformatf("%s idx %0h", tag, i), bus_rdata, mdl_read(i));
    endtask

    task automatic sweep_all(input string tag);
        for (int i = 0; i < 320; i++) rd(i, tag);
    endtask

    initial begin
        do_reset();

        // R1: defaults after reset
        sweep_all("R1 reset");

        // R10: open writes to every ordinary word
        for (int i = 1; i < 320; i++) wr(i, 32'(i) * 32'h0101_0107 ^ 32'hA5A5_5A5A);
        sweep_all("R10 open");

        // R8: read-only fields of the configuration word
        wr(1, 32'hFFFF_FFFF);
        rd(1, "R8 conf all-ones");
        wr(1, 32'h0000_0000);
        rd(1, "R8 conf zero");
        wr(1, 32'hFFFF_FFFF);

        // R9: beyond the space reads 0, writes touch nothing
        for (int i = 320; i < 1024; i += 37) rd(i, "R9 out-of-range");
        rd(1023, "R9 out-of-range top");
        wr(320, 32'h1234_5678);
        wr(1023, 32'h8765_4321);
        sweep_all("R9 no alias");

        // R6 and R7: RAM-size sweep
        foreach (ram_list[k]) begin
            @(negedge clk);
            ram_mib = 12'(ram_list[k]);
            rd(1, (size_code_of(ram_list[k]) < 0) ? "R7 size code" : "R6 size code");
            chk($sformatf("R7 size_err mib %0d", ram_list[k]), 32'(size_err),
                32'(size_code_of(ram_list[k]) < 0));
        end
        @(negedge clk);
        ram_mib = 12'd1024;

        // R2 and R3: soft lock
        wr(0, 32'h1234_5678);
        rd(0, "R2 soft state");
        for (int i = 1; i < 330; i++) wr(i, ~(32'(i) * 32'h0003_0005));
        sweep_all("R3 soft blocked");
        wr(0, 32'h0000_0001);
        rd(0, "R3 soft prot still writable");
        wr(0, 32'hFC60_0309);
        rd(0, "R2 unlock");
        wr(2, 32'hCAFE_0002);
        rd(2, "R2 open after unlock");

        // R4 and R5: hard lock
        wr(0, 32'hDEAD_DEAD);
        rd(0, "R4 hard state");
        wr(0, 32'hFC60_0309);
        rd(0, "R4 unlock ignored");
        wr(0, 32'h0000_0000);
        rd(0, "R4 other key ignored");
        for (int i = 1; i < 320; i++) wr(i, 32'(i) ^ 32'h5EED_0000);
        sweep_all("R4 hard blocked");
        rd('h14, "R5 free word");
        rd('h2D, "R5 free word");

        // R1: reset leaves the hard lock
        do_reset();
        sweep_all("R1 reset after hard");
        wr(5, 32'h0BAD_F00D);
        rd(5, "R10 open after reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    int ram_list [9] = '{256, 512, 1024, 2048, 0, 128, 300, 4095, 768};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule